// File: doc/BRIEF.md
# Iterative Column-Norm Sorting Controller

This block holds the ordering state for a sorted QR decomposition of a complex channel matrix with up to four columns. It does not do the rotations. Before the first step it builds one metric per column by summing the squared magnitude of every valid matrix entry it receives. At each step it picks, from the columns not yet processed, the one whose metric is smallest. It records that choice by exchanging two slots of a permutation table. The same table serves as a column address remapper, so the matrix store never moves any data.

After each step the rotation engine sends back the entries of the row it has just finished. In iterative mode the block subtracts their squared magnitudes from the metrics of the remaining columns. The next pivot then reflects what is left of each column. Choosing a pivot is held off while rotations are still outstanding and while a metric subtraction is landing. A mode input selects no sorting, one-time sorting on the initial metrics, or iterative sorting.

Column positions and physical column numbers count from 0. The table `permFlat` holds at position p, in bits [p*2 +: 2], the physical column currently seen at logical position p.

Top module: `colsort_ctrl`

## Requirements
- R1: After reset or a `start` pulse, `permFlat` is the identity (position p holds p), `stepIdx` is 0, `selValid` is 0 and `sortDone` is 0 while `cfgCols` > 0.
- R2: An entry with `entryValid`=1 and `entrySub`=0 adds re²+im² to the metric of physical column `entryCol`, but only if `entryRow` < `cfgRows` and `entryCol` < `cfgCols`. Any other such entry is ignored.
- R3: In mode 1 (one-time) and mode 2 (iterative), the pivot at step s is the position k in s..`cfgCols`-1 whose column has the smallest metric. On a tie the lowest position wins.
- R4: A selection is accepted in a cycle where a request is pending. At the next clock, the entries at positions `stepIdx` and k of `permFlat` are exchanged and `stepIdx` increments. For that one cycle `selValid`=1, `selPos`=k and `selPhys` is the physical column that now sits at the step position.
- R5: In mode 0 (off), and in mode 3, which acts as off, the pivot is always the step position and `permFlat` stays the identity.
- R6: In mode 2, an entry with `entrySub`=1 and `entryCol` < `cfgCols` subtracts re²+im² from the metric of the column at logical position `entryCol`. If the subtraction would go below zero, the metric becomes 0.
- R7: In modes 0, 1 and 3, entries with `entrySub`=1 leave every metric unchanged.
- R8: A `selReq` pulse is remembered. No selection is accepted in a cycle with `rotPending`=1 or with a mode-2 subtract entry. The remembered request is accepted in the first cycle with neither condition.
- R9: `rdPhysCol` is the `permFlat` entry at position `rdLogCol`, and `wrPhysCol` is the entry at position `wrLogCol`. Both outputs are combinational in the same cycle.
- R10: `sortDone` is 1 once `stepIdx` equals `cfgCols`. After that, `selReq` produces no `selValid` and leaves `permFlat` unchanged.
- R11: A `start` pulse in the middle of a sort clears every metric, restores the identity permutation and resets `stepIdx` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new matrix: clears metrics, permutation and step |
| cfgMode | input | 2 | 0 off, 1 one-time, 2 iterative, 3 off |
| cfgCols | input | 3 | Number of columns in use (1..4) |
| cfgRows | input | 3 | Number of rows in use (cfgCols..4) |
| entryValid | input | 1 | Entry present this cycle |
| entrySub | input | 1 | 0: initial accumulation (physical column); 1: finished-row subtraction (logical position) |
| entryRow | input | 2 | Row index of the entry |
| entryCol | input | 2 | Column index of the entry |
| entryRe | input | 12 | Real part of the entry, signed |
| entryIm | input | 12 | Imaginary part of the entry, signed |
| rotPending | input | 1 | Rotations still outstanding; holds off selection |
| selReq | input | 1 | Request the pivot for the current step |
| selValid | output | 1 | One-cycle pulse after a selection is accepted |
| selPos | output | 2 | Logical position chosen as pivot |
| selPhys | output | 2 | Physical column moved into the step position |
| stepIdx | output | 3 | Number of steps completed |
| sortDone | output | 1 | All columns have been selected |
| permFlat | output | 8 | Permutation table, position p in bits [p*2 +: 2] |
| rdLogCol | input | 2 | Logical column of the read address |
| rdPhysCol | output | 2 | Remapped physical read column |
| wrLogCol | input | 2 | Logical column of the write address |
| wrPhysCol | output | 2 | Remapped physical write column |

## Verification
A metric subtraction and a pivot request can arrive in the same cycle. If the selection used the metrics as they stood before that edge, it would miss the update. The bench provokes this case by raising `selReq` in the same cycle as a subtract entry that turns a different column into the minimum. It then checks that `selValid` stays low for that cycle and that the pivot reported one cycle later is the column made smallest by the subtraction. A pivot request raised while `rotPending` is high is handled the same way: the bench checks that the request is held through the stall and accepted exactly one clock after the stall ends.

// File: rtl/colsort_pkg.sv
package colsort_pkg;

  // Sorting modes; the unused code 3 behaves as off.
  typedef enum logic [1:0] {
    SORT_OFF  = 2'd0,
    SORT_ONCE = 2'd1,
    SORT_ITER = 2'd2
  } sort_mode_e;

  // Strobes the control hands to the metric/permutation datapath.
  typedef struct packed {
    logic clear;     // wipe metrics, restore identity order
    logic accum;     // add entry metric to a physical column
    logic subtract;  // remove entry metric from a logical position
    logic swap;      // accept the pivot of the current step
  } dp_strobe_t;

endpackage

// File: rtl/colsort_dp.sv
module colsort_dp
  import colsort_pkg::*;
#(
  parameter int MAX_COLS  = 4,
  parameter int MAX_ROWS  = 4,
  parameter int DATA_W    = 12,
  parameter int NORM_KIND = 0,  // 0 squared l2, 1 l1, 2 l-infinity
  localparam int COL_W = $clog2(MAX_COLS),
  localparam int CNT_W = $clog2(MAX_COLS + 1),
  localparam int MET_W = 2 * DATA_W + $clog2(MAX_ROWS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dp_strobe_t                 strb,
  input  logic [1:0]                 mode,
  input  logic [CNT_W-1:0]           cfgCols,
  input  logic [CNT_W-1:0]           step,
  input  logic [COL_W-1:0]           entryCol,
  input  logic signed [DATA_W-1:0]   entryRe,
  input  logic signed [DATA_W-1:0]   entryIm,
  output logic [COL_W-1:0]           selPos,
  output logic [COL_W-1:0]           selPhys,
  output logic [MAX_COLS*COL_W-1:0]  permFlat,
  input  logic [COL_W-1:0]           rdLogCol,
  output logic [COL_W-1:0]           rdPhysCol,
  input  logic [COL_W-1:0]           wrLogCol,
  output logic [COL_W-1:0]           wrPhysCol
);

  logic [MET_W-1:0] metric [MAX_COLS];
  logic [COL_W-1:0] perm   [MAX_COLS];

  // Magnitudes of the entry parts, one bit wider so the most negative value fits.
  logic signed [DATA_W:0] reX, imX;
  logic [DATA_W:0]        absRe, absIm;
  logic [MET_W-1:0]       entMet;

  assign reX   = {entryRe[DATA_W-1], entryRe};
  assign imX   = {entryIm[DATA_W-1], entryIm};
  assign absRe = reX[DATA_W] ? -reX : reX;
  assign absIm = imX[DATA_W] ? -imX : imX;

  generate
    if (NORM_KIND == 0) begin : g_l2
      logic [MET_W-1:0] reW, imW;
      assign reW    = MET_W'(absRe);
      assign imW    = MET_W'(absIm);
      assign entMet = reW * reW + imW * imW;
    end else if (NORM_KIND == 1) begin : g_l1
      assign entMet = MET_W'(absRe) + MET_W'(absIm);
    end else begin : g_linf
      assign entMet = (absRe > absIm) ? MET_W'(absRe) : MET_W'(absIm);
    end
  endgenerate

  logic [COL_W-1:0] stepPos;
  logic [COL_W-1:0] subIdx;
  logic [COL_W-1:0] pivot;
  logic [MET_W-1:0] best;
  logic             sorting;

  assign stepPos = COL_W'(step);
  assign subIdx  = perm[entryCol];
  assign sorting = (mode == SORT_ONCE) || (mode == SORT_ITER);

  // Pivot search: start at the step position, replace only on strictly smaller.
  always_comb begin
    pivot = stepPos;
    best  = metric[perm[stepPos]];
    if (sorting) begin
      for (int p = 0; p < MAX_COLS; p++) begin
        if (CNT_W'(p) > step && CNT_W'(p) < cfgCols && metric[perm[p]] < best) begin
          best  = metric[perm[p]];
          pivot = COL_W'(p);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < MAX_COLS; p++) begin
        metric[p] <= '0;
        perm[p]   <= COL_W'(p);
      end
      selPos  <= '0;
      selPhys <= '0;
    end else if (strb.clear) begin
      for (int p = 0; p < MAX_COLS; p++) begin
        metric[p] <= '0;
        perm[p]   <= COL_W'(p);
      end
      selPos  <= '0;
      selPhys <= '0;
    end else begin
      if (strb.accum) begin
        metric[entryCol] <= metric[entryCol] + entMet;
      end
      if (strb.subtract) begin
        metric[subIdx] <= (metric[subIdx] > entMet) ? metric[subIdx] - entMet : '0;
      end
      if (strb.swap) begin
        perm[stepPos] <= perm[pivot];
        perm[pivot]   <= perm[stepPos];
        selPos        <= pivot;
        selPhys       <= perm[pivot];
      end
    end
  end

  generate
    for (genvar g = 0; g < MAX_COLS; g++) begin : g_flat
      assign permFlat[g*COL_W +: COL_W] = perm[g];
    end
  endgenerate

  // Column address remapping on both access paths.
  assign rdPhysCol = perm[rdLogCol];
  assign wrPhysCol = perm[wrLogCol];

  logic [MAX_COLS-1:0] permSeen;
  always_comb begin
    permSeen = '0;
    for (int p = 0; p < MAX_COLS; p++) permSeen[perm[p]] = 1'b1;
  end

  AST_PERM_IS_BIJECTION: assert property (@(posedge clk) disable iff (!rstN)
    permSeen == {MAX_COLS{1'b1}}) else $error("permutation lost a column"); // R4

  AST_OFF_KEEPS_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (strb.swap && !sorting) |=> $stable(permFlat)) else $error("order changed while off"); // R5

endmodule

// File: rtl/colsort_fsm.sv
module colsort_fsm
  import colsort_pkg::*;
#(
  parameter int MAX_COLS = 4,
  parameter int MAX_ROWS = 4,
  localparam int COL_W  = $clog2(MAX_COLS),
  localparam int ROW_W  = $clog2(MAX_ROWS),
  localparam int CNT_W  = $clog2(MAX_COLS + 1),
  localparam int RCNT_W = $clog2(MAX_ROWS + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        cfgMode,
  input  logic [CNT_W-1:0]  cfgCols,
  input  logic [RCNT_W-1:0] cfgRows,
  input  logic              entryValid,
  input  logic              entrySub,
  input  logic [ROW_W-1:0]  entryRow,
  input  logic [COL_W-1:0]  entryCol,
  input  logic              rotPending,
  input  logic              selReq,
  output dp_strobe_t        strb,
  output logic [CNT_W-1:0]  step,
  output logic              selValid,
  output logic              sortDone
);

  logic rowOk, colOk, iterMode, subBusy, reqPend, want, fire;

  assign rowOk    = RCNT_W'(entryRow) < cfgRows;
  assign colOk    = CNT_W'(entryCol) < cfgCols;
  assign iterMode = (cfgMode == SORT_ITER);
  assign subBusy  = entryValid && entrySub && iterMode;
  assign sortDone = (step >= cfgCols);

  assign want = (selReq || reqPend) && !sortDone;
  assign fire = want && !rotPending && !subBusy && !start;

  assign strb.clear    = start;
  assign strb.accum    = !start && entryValid && !entrySub && rowOk && colOk;
  assign strb.subtract = !start && subBusy && colOk;
  assign strb.swap     = fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      step     <= '0;
      reqPend  <= 1'b0;
      selValid <= 1'b0;
    end else if (start) begin
      step     <= '0;
      reqPend  <= 1'b0;
      selValid <= 1'b0;
    end else begin
      selValid <= fire;
      reqPend  <= want && !fire;
      if (fire) step <= step + CNT_W'(1);
    end
  end

  AST_SEL_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> $past(!rotPending)) else $error("pivot taken during rotations"); // R8

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> step == $past(step) + CNT_W'(1)) else $error("step did not advance"); // R4

  AST_NO_SEL_PAST_END: assert property (@(posedge clk) disable iff (!rstN)
    selValid |-> $past(step) < $past(cfgCols)) else $error("pivot beyond last column"); // R10

endmodule

// File: rtl/colsort_ctrl.sv
module colsort_ctrl
  import colsort_pkg::*;
#(
  parameter int MAX_COLS  = 4,
  parameter int MAX_ROWS  = 4,
  parameter int DATA_W    = 12,
  parameter int NORM_KIND = 0,
  localparam int COL_W  = $clog2(MAX_COLS),
  localparam int ROW_W  = $clog2(MAX_ROWS),
  localparam int CNT_W  = $clog2(MAX_COLS + 1),
  localparam int RCNT_W = $clog2(MAX_ROWS + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      start,
  input  logic [1:0]                cfgMode,
  input  logic [CNT_W-1:0]          cfgCols,
  input  logic [RCNT_W-1:0]         cfgRows,
  input  logic                      entryValid,
  input  logic                      entrySub,
  input  logic [ROW_W-1:0]          entryRow,
  input  logic [COL_W-1:0]          entryCol,
  input  logic signed [DATA_W-1:0]  entryRe,
  input  logic signed [DATA_W-1:0]  entryIm,
  input  logic                      rotPending,
  input  logic                      selReq,
  output logic                      selValid,
  output logic [COL_W-1:0]          selPos,
  output logic [COL_W-1:0]          selPhys,
  output logic [CNT_W-1:0]          stepIdx,
  output logic                      sortDone,
  output logic [MAX_COLS*COL_W-1:0] permFlat,
  input  logic [COL_W-1:0]          rdLogCol,
  output logic [COL_W-1:0]          rdPhysCol,
  input  logic [COL_W-1:0]          wrLogCol,
  output logic [COL_W-1:0]          wrPhysCol
);

  dp_strobe_t strb;

  colsort_fsm #(.MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS)) u_fsm (
    .clk(clk), .rstN(rstN), .start(start), .cfgMode(cfgMode),
    .cfgCols(cfgCols), .cfgRows(cfgRows), .entryValid(entryValid),
    .entrySub(entrySub), .entryRow(entryRow), .entryCol(entryCol),
    .rotPending(rotPending), .selReq(selReq), .strb(strb),
    .step(stepIdx), .selValid(selValid), .sortDone(sortDone)
  );

  colsort_dp #(.MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS), .DATA_W(DATA_W),
               .NORM_KIND(NORM_KIND)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .mode(cfgMode), .cfgCols(cfgCols),
    .step(stepIdx), .entryCol(entryCol), .entryRe(entryRe), .entryIm(entryIm),
    .selPos(selPos), .selPhys(selPhys), .permFlat(permFlat),
    .rdLogCol(rdLogCol), .rdPhysCol(rdPhysCol),
    .wrLogCol(wrLogCol), .wrPhysCol(wrPhysCol)
  );

endmodule

// File: tb/colsort_ctrl_test.sv
module colsort_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 4;
  localparam int COL_W = 2;
  localparam int DATA_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] cfgMode = 2'd2;
  logic [2:0] cfgCols = 3'd4;
  logic [2:0] cfgRows = 3'd4;
  logic entryValid = 1'b0, entrySub = 1'b0;
  logic [1:0] entryRow = '0, entryCol = '0;
  logic signed [DATA_W-1:0] entryRe = '0, entryIm = '0;
  logic rotPending = 1'b0, selReq = 1'b0;
  logic selValid, sortDone;
  logic [1:0] selPos, selPhys, rdPhysCol, wrPhysCol;
  logic [1:0] rdLogCol = '0, wrLogCol = '0;
  logic [2:0] stepIdx;
  logic [NCOL*COL_W-1:0] permFlat;

  colsort_ctrl uut (
    .clk(clk), .rstN(rstN), .start(start), .cfgMode(cfgMode), .cfgCols(cfgCols),
    .cfgRows(cfgRows), .entryValid(entryValid), .entrySub(entrySub),
    .entryRow(entryRow), .entryCol(entryCol), .entryRe(entryRe), .entryIm(entryIm),
    .rotPending(rotPending), .selReq(selReq), .selValid(selValid), .selPos(selPos),
    .selPhys(selPhys), .stepIdx(stepIdx), .sortDone(sortDone), .permFlat(permFlat),
    .rdLogCol(rdLogCol), .rdPhysCol(rdPhysCol), .wrLogCol(wrLogCol), .wrPhysCol(wrPhysCol)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  // Reference state built from the requirements.
  int mMet[NCOL];
  int mPerm[NCOL];
  int mStep, mMode, mCols, mRows;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic checkPerm(string tag);
    for (int p = 0; p < NCOL; p++) chk(tag, int'(permFlat[p*COL_W +: COL_W]), mPerm[p]);
  endtask

  function automatic int modelPivot();
    int k = mStep;
    if (mMode == 1 || mMode == 2)
      for (int p = mStep + 1; p < mCols; p++)
        if (mMet[mPerm[p]] < mMet[mPerm[k]]) k = p;
    return k;
  endfunction

  task automatic doStart(int mode, int cols, int rows);
    cfgMode = 2'(mode); cfgCols = 3'(cols); cfgRows = 3'(rows);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mMode = mode; mCols = cols; mRows = rows; mStep = 0;
    for (int p = 0; p < NCOL; p++) begin mMet[p] = 0; mPerm[p] = p; end
  endtask

  task automatic modelEntry(bit sub, int row, int col, int re, int im);
    int m = re*re + im*im;
    if (!sub && row < mRows && col < mCols) mMet[col] += m;
    if (sub && mMode == 2 && col < mCols) begin
      int t = mPerm[col];
      mMet[t] = (mMet[t] > m) ? mMet[t] - m : 0;
    end
  endtask

  task automatic driveEntry(bit sub, int row, int col, int re, int im);
    entryValid = 1'b1; entrySub = sub;
    entryRow = 2'(row); entryCol = 2'(col);
    entryRe = DATA_W'(re); entryIm = DATA_W'(im);
  endtask

  task automatic send(bit sub, int row, int col, int re, int im);
    driveEntry(sub, row, col, re, im);
    @(negedge clk);
    entryValid = 1'b0; entrySub = 1'b0;
    modelEntry(sub, row, col, re, im);
  endtask

  // Checks the outputs one cycle after acceptance and advances the model.
  task automatic finishSel(string tag);
    int k = modelPivot();
    int tmp;
    chk({tag, " selValid"}, int'(selValid), 1);
    chk({tag, " selPos"}, int'(selPos), k);
    chk({tag, " selPhys"}, int'(selPhys), mPerm[k]);
    tmp = mPerm[mStep]; mPerm[mStep] = mPerm[k]; mPerm[k] = tmp;
    mStep++;
    chk({tag, " stepIdx"}, int'(stepIdx), mStep);
    checkPerm({tag, " perm"});
  endtask

  task automatic doSelect(string tag);
    selReq = 1'b1;
    @(negedge clk);
    selReq = 1'b0;
    finishSel(tag);
  endtask

  task automatic testReset();
    chk("R1 selValid", int'(selValid), 0);
    chk("R1 stepIdx", int'(stepIdx), 0);
    chk("R1 sortDone", int'(sortDone), 0);
    for (int p = 0; p < NCOL; p++) mPerm[p] = p;
    checkPerm("R1 identity");
    rdLogCol = 2'd2; wrLogCol = 2'd1; #1;
    chk("R9 rd identity", int'(rdPhysCol), 2);
    chk("R9 wr identity", int'(wrPhysCol), 1);
  endtask

  task automatic testIterative();
    doStart(2, 4, 4);
    send(0, 0, 0, 7, 1); send(0, 0, 1, 3, 1);
    send(0, 0, 2, 5, 2); send(0, 1, 2, 1, 0);
    send(0, 3, 3, 1, 3);
    doSelect("R3 tie lowest step0");        // metrics 50,10,30,10 -> pos1
    send(1, 0, 1, 6, 3); send(1, 0, 2, 2, 0);
    send(1, 0, 3, 4, 2);                     // R6 clamp on phys3
    doSelect("R6 update step1");
    rdLogCol = 2'd1; wrLogCol = 2'd3; #1;
    chk("R9 rd remap", int'(rdPhysCol), mPerm[1]);
    chk("R9 wr remap", int'(wrPhysCol), mPerm[3]);
    @(negedge clk);
    doSelect("R3 step2");
    doSelect("R4 last step");
    chk("R10 sortDone", int'(sortDone), 1);
    selReq = 1'b1;
    @(negedge clk);
    selReq = 1'b0;
    chk("R10 no select after done", int'(selValid), 0);
    @(negedge clk);
    chk("R10 still no select", int'(selValid), 0);
    checkPerm("R10 perm unchanged");
  endtask

  task automatic testStall();
    doStart(2, 2, 2);
    send(0, 0, 0, 2, 0); send(0, 0, 1, 1, 0);
    selReq = 1'b1; rotPending = 1'b1;
    @(negedge clk);
    selReq = 1'b0;
    chk("R8 held while pending", int'(selValid), 0);
    @(negedge clk);
    chk("R8 still held", int'(selValid), 0);
    rotPending = 1'b0;
    @(negedge clk);
    finishSel("R8 released");
  endtask

  task automatic testCollision();
    doStart(2, 3, 3);
    send(0, 0, 0, 3, 1); send(0, 0, 1, 4, 2); send(0, 0, 2, 5, 0);
    doSelect("R3 pre-collision");
    selReq = 1'b1;
    driveEntry(1, 0, 2, 4, 0);
    @(negedge clk);
    selReq = 1'b0; entryValid = 1'b0; entrySub = 1'b0;
    modelEntry(1, 0, 2, 4, 0);
    chk("R8 stalled by subtract", int'(selValid), 0);
    @(negedge clk);
    finishSel("R8 R6 collision uses updated metric");
  endtask

  task automatic testOnce();
    doStart(1, 4, 4);
    send(0, 0, 0, 6, 2); send(0, 0, 1, 2, 1);
    send(0, 0, 2, 3, 2); send(0, 0, 3, 1, 0);
    doSelect("R3 once step0");
    send(1, 0, 2, 3, 2);                     // ignored in one-time mode
    doSelect("R7 subtract ignored");
  endtask

  task automatic testOff();
    doStart(0, 3, 3);
    send(0, 0, 0, 9, 0); send(0, 0, 1, 1, 0); send(0, 0, 2, 2, 0);
    doSelect("R5 off step0");
    doSelect("R5 off step1");
    doSelect("R5 off step2");
    chk("R10 done off", int'(sortDone), 1);
  endtask

  task automatic testFilter();
    doStart(2, 3, 3);
    send(0, 0, 0, 1, 0);
    send(0, 3, 0, 40, 0);                    // row beyond cfgRows
    send(0, 0, 1, 2, 0); send(0, 0, 2, 3, 0);
    send(0, 0, 3, 0, 0);
    doSelect("R2 row filter");
  endtask

  task automatic testRestart();
    doStart(2, 4, 4);
    send(0, 0, 0, 10, 0); send(0, 0, 1, 2, 0);
    doSelect("R3 before restart");
    doStart(2, 4, 4);
    chk("R11 stepIdx", int'(stepIdx), 0);
    checkPerm("R11 identity");
    send(0, 0, 1, 5, 0); send(0, 0, 2, 1, 0); send(0, 0, 3, 1, 0);
    doSelect("R11 metrics cleared");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIterative();
    testStall();
    testCollision();
    testOnce();
    testOff();
    testFilter();
    testRestart();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule